// File: doc/BRIEF.md
# Memory Error Capture Register Block

This block sits beside a memory controller's error-correction logic and records what software needs to know about the first memory errors it sees. It takes two event streams, one for corrected single-bit errors and one for uncorrectable multi-bit errors. Each event arrives with the failing physical address and the memory row it hit. The block keeps the 4 KB page of the captured error together with two sticky type flags. It also keeps a status word with a seen flag and a first-error row for each error type, and a command word that chooses which error types raise a system-error pulse.

Captured data stays frozen until software acknowledges it by writing ones to the flags. A later error of a type that is already flagged is dropped. A multi-bit error has priority over a single-bit one for the page address. Software reaches all three words through a flat select/write/read port. Reads are combinational and writes take effect on the clock edge.

Top module: `mem_err_capture`

## Requirements
- R1: While reset is held, and on the first cycles after it is released, every register field reads zero and `serr_o` is low.
- R2: Select 0 reads the address word: bits 31:12 are the captured page (physical address bits 31:12), bit 1 is the multi-bit flag, bit 0 is the single-bit flag, and bits 11:2 read zero.
- R3: A single-bit event sampled while both address flags are clear loads its page into bits 31:12 and sets bit 0. Both are visible in the cycle after the sampling edge.
- R4: While a flag is set, further events of that type leave the page unchanged. While the multi-bit flag is set, no single-bit event changes the page.
- R5: A multi-bit event sampled while the multi-bit flag is clear loads its page and sets bit 1, replacing a page captured from a single-bit error. When both types arrive on the same edge, the multi-bit address is kept and both flags are set.
- R6: A write to select 0 clears each flag whose data bit (bit 0 single-bit, bit 1 multi-bit) is 1. Zero bits leave their flag untouched, and the page is never altered by a write.
- R7: Select 1 reads the status word: bit 0 single-bit seen, bits 3:1 row of the first single-bit error, bit 4 multi-bit seen, bits 7:5 row of the first multi-bit error, all higher bits zero. The first event of a type with its seen bit clear sets that bit and latches its row. Later events of that type are ignored until it is cleared.
- R8: A write to select 1 with data bit 0 (or bit 4) set clears the single-bit (or multi-bit) seen bit and zeroes its row field. Zero bits have no effect.
- R9: Select 2 is the command word. Bits 1:0 are written and read back (bit 1 enables signalling on multi-bit errors, bit 0 on single-bit errors), and higher bits read zero.
- R10: `serr_o` is high for exactly the one cycle after an edge that sets an address flag whose command enable (as held before that edge) is 1. Events that are blocked or disabled raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sbe_evt | input | 1 | Single-bit error event, one cycle per error |
| sbe_addr | input | 32 | Physical address of the single-bit error |
| sbe_row | input | 3 | Memory row of the single-bit error |
| mbe_evt | input | 1 | Multi-bit error event, one cycle per error |
| mbe_addr | input | 32 | Physical address of the multi-bit error |
| mbe_row | input | 3 | Memory row of the multi-bit error |
| reg_sel | input | 2 | Word select: 0 address, 1 status, 2 command, 3 unused (reads zero) |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected word |
| serr_o | output | 1 | System-error pulse |

## Verification
An event or write sampled at a clock edge changes the stored words at that edge. Because reads are combinational, the new value is due on `reg_rdata` as soon as the select is changed in the following cycle. `serr_o` comes from one register and is therefore due in that same cycle after the edge and gone one cycle later. The bench drives each stimulus for exactly one edge and checks `serr_o` one nanosecond after the edge. It then steps the select through the three words and reads each half a nanosecond apart, all before the next edge. Its model is updated once per edge from the state held before that edge, so a result is never compared a cycle early or late.

// File: rtl/mec_pkg.sv
package mec_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int KIND_SBE  = 0;
  localparam int KIND_MBE  = 1;
  localparam int NUM_KINDS = 2;
endpackage

// File: rtl/mec_rst_sync.sv
module mec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mec_addr_capture.sv
module mec_addr_capture
  import mec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sbe_evt,
  input  logic [ADDR_W-1:0]    sbe_addr,
  input  logic                 mbe_evt,
  input  logic [ADDR_W-1:0]    mbe_addr,
  input  logic [NUM_KINDS-1:0] clr_mask,
  output logic [PAGE_W-1:0]    page_q,
  output logic [NUM_KINDS-1:0] flag_q,
  output logic [NUM_KINDS-1:0] cap_o
);
  logic [PAGE_W-1:0]    page_d;
  logic                 page_en;
  logic [NUM_KINDS-1:0] flag_d;
  logic                 flag_en;

  always_comb begin
    cap_o[KIND_SBE] = sbe_evt & ~flag_q[KIND_SBE];
    cap_o[KIND_MBE] = mbe_evt & ~flag_q[KIND_MBE];
    // multi-bit wins the page; single-bit only loads an empty page
    page_en = cap_o[KIND_MBE] | (cap_o[KIND_SBE] & ~flag_q[KIND_MBE]);
    page_d  = cap_o[KIND_MBE] ? mbe_addr[ADDR_W-1:PAGE_SHIFT]
                              : sbe_addr[ADDR_W-1:PAGE_SHIFT];
    flag_d  = (flag_q & ~clr_mask) | cap_o;
    flag_en = (|cap_o) | (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      flag_q <= '0;
    end else begin
      if (page_en) page_q <= page_d;
      if (flag_en) flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/mec_err_lane.sv
module mec_err_lane #(
  parameter int ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [ROW_W-1:0] row,
  input  logic             clr,
  output logic             seen_q,
  output logic [ROW_W-1:0] row_q
);
  logic             cap;
  logic             lane_en;
  logic             seen_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    cap     = evt & ~seen_q;
    lane_en = cap | (clr & seen_q);
    seen_d  = cap;
    row_d   = cap ? row : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      row_q  <= '0;
    end else if (lane_en) begin
      seen_q <= seen_d;
      row_q  <= row_d;
    end
  end
endmodule

// File: rtl/mec_regif.sv
module mec_regif
  import mec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ROW_W      = 3,
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT,
  localparam int LANE_W    = ROW_W + 1,
  localparam int STAT_W    = NUM_KINDS * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_sel,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_wdata,
  input  logic [PAGE_W-1:0]    page_q,
  input  logic [NUM_KINDS-1:0] addr_flag,
  input  logic [STAT_W-1:0]    stat_vec,
  input  logic [NUM_KINDS-1:0] addr_cap,
  output logic [ADDR_W-1:0]    reg_rdata,
  output logic [NUM_KINDS-1:0] addr_clr,
  output logic [NUM_KINDS-1:0] stat_clr,
  output logic [NUM_KINDS-1:0] cmd_q,
  output logic                 serr_o
);
  reg_sel_e             sel;
  logic                 cmd_en;
  logic [NUM_KINDS-1:0] cmd_d;
  logic                 serr_d;

  always_comb begin
    sel    = reg_sel_e'(reg_sel);
    cmd_en = reg_wr && (sel == SEL_CMD);
    cmd_d  = reg_wdata[NUM_KINDS-1:0];
    serr_d = |(addr_cap & cmd_q);
    addr_clr = (reg_wr && (sel == SEL_ADDR)) ? reg_wdata[NUM_KINDS-1:0] : '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      stat_clr[k] = reg_wr && (sel == SEL_STAT) && reg_wdata[k*LANE_W];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_ADDR: begin
        reg_rdata[ADDR_W-1:PAGE_SHIFT] = page_q;
        reg_rdata[NUM_KINDS-1:0]       = addr_flag;
      end
      SEL_STAT: reg_rdata[STAT_W-1:0]    = stat_vec;
      SEL_CMD:  reg_rdata[NUM_KINDS-1:0] = cmd_q;
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      serr_o <= 1'b0;
    end else begin
      if (cmd_en) cmd_q <= cmd_d;
      serr_o <= serr_d;
    end
  end
endmodule

// File: rtl/mem_err_capture.sv
module mem_err_capture
  import mec_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ROW_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sbe_evt,
  input  logic [ADDR_W-1:0] sbe_addr,
  input  logic [ROW_W-1:0]  sbe_row,
  input  logic              mbe_evt,
  input  logic [ADDR_W-1:0] mbe_addr,
  input  logic [ROW_W-1:0]  mbe_row,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              serr_o
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int LANE_W = ROW_W + 1;
  localparam int STAT_W = NUM_KINDS * LANE_W;

  logic                 rst_sync_n;
  logic [PAGE_W-1:0]    page_q;
  logic [NUM_KINDS-1:0] addr_flag;
  logic [NUM_KINDS-1:0] addr_cap;
  logic [NUM_KINDS-1:0] addr_clr;
  logic [NUM_KINDS-1:0] stat_clr;
  logic [NUM_KINDS-1:0] cmd_q;
  logic [STAT_W-1:0]    stat_vec;
  logic [NUM_KINDS-1:0] lane_evt;
  logic [ROW_W-1:0]     lane_row [NUM_KINDS];

  assign lane_evt[KIND_SBE] = sbe_evt;
  assign lane_evt[KIND_MBE] = mbe_evt;
  assign lane_row[KIND_SBE] = sbe_row;
  assign lane_row[KIND_MBE] = mbe_row;

  mec_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mec_addr_capture #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_addr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sbe_evt  (sbe_evt),
    .sbe_addr (sbe_addr),
    .mbe_evt  (mbe_evt),
    .mbe_addr (mbe_addr),
    .clr_mask (addr_clr),
    .page_q   (page_q),
    .flag_q   (addr_flag),
    .cap_o    (addr_cap)
  );

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_lane
    logic             seen_q;
    logic [ROW_W-1:0] row_q;
    mec_err_lane #(.ROW_W(ROW_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .evt    (lane_evt[k]),
      .row    (lane_row[k]),
      .clr    (stat_clr[k]),
      .seen_q (seen_q),
      .row_q  (row_q)
    );
    assign stat_vec[k*LANE_W]            = seen_q;
    assign stat_vec[k*LANE_W+1 +: ROW_W] = row_q;
  end

  mec_regif #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ROW_W(ROW_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .page_q    (page_q),
    .addr_flag (addr_flag),
    .stat_vec  (stat_vec),
    .addr_cap  (addr_cap),
    .reg_rdata (reg_rdata),
    .addr_clr  (addr_clr),
    .stat_clr  (stat_clr),
    .cmd_q     (cmd_q),
    .serr_o    (serr_o)
  );
endmodule

// File: rtl/mec_checker.sv
module mec_checker #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ROW_W      = 3,
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT,
  localparam int LANE_W    = ROW_W + 1,
  localparam int STAT_W    = 2 * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sbe_evt,
  input logic [ADDR_W-1:0] sbe_addr,
  input logic              mbe_evt,
  input logic [ADDR_W-1:0] mbe_addr,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic [PAGE_W-1:0] page_q,
  input logic [1:0]        addr_flag,
  input logic [STAT_W-1:0] stat_vec,
  input logic [1:0]        cmd_q,
  input logic              serr_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (addr_flag == 2'b00) && !serr_o && (stat_vec == '0));

  assert_sbe_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sbe_evt && !mbe_evt && (addr_flag == 2'b00)
    |=> addr_flag[0] && (page_q == $past(sbe_addr[ADDR_W-1:PAGE_SHIFT])));

  assert_mbe_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mbe_evt && !addr_flag[1]
    |=> addr_flag[1] && (page_q == $past(mbe_addr[ADDR_W-1:PAGE_SHIFT])));

  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_flag[1] |=> $stable(page_q));

  assert_w1c_sbe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_sel == 2'd0) && reg_wdata[0] && addr_flag[0] |=> !addr_flag[0]);

  assert_w1c_mbe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_sel == 2'd0) && reg_wdata[1] && addr_flag[1] |=> !addr_flag[1]);

  assert_sbe_row_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_vec[0] |-> (stat_vec[ROW_W:1] == '0));

  assert_mbe_row_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_vec[LANE_W] |-> (stat_vec[STAT_W-1:LANE_W+1] == '0));

  assert_serr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> ($rose(addr_flag[0]) && $past(cmd_q[0])) ||
               ($rose(addr_flag[1]) && $past(cmd_q[1])));
endmodule

bind mem_err_capture mec_checker #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ROW_W(ROW_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sbe_evt   (sbe_evt),
  .sbe_addr  (sbe_addr),
  .mbe_evt   (mbe_evt),
  .mbe_addr  (mbe_addr),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .page_q    (page_q),
  .addr_flag (addr_flag),
  .stat_vec  (stat_vec),
  .cmd_q     (cmd_q),
  .serr_o    (serr_o)
);

// File: tb/mem_err_capture_tb.sv
`timescale 1ns/100ps
module mem_err_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sbe_evt, mbe_evt, reg_wr;
  logic [31:0] sbe_addr, mbe_addr, reg_wdata, reg_rdata;
  logic [2:0]  sbe_row, mbe_row;
  logic [1:0]  reg_sel;
  logic        serr_o;

  int n_tests = 0;
  int n_fail  = 0;

  bit [19:0] e_page;
  bit [1:0]  e_flag;
  bit [1:0]  e_seen;
  bit [2:0]  e_row0, e_row1;
  bit [1:0]  e_cmd;
  bit        e_serr;

  always #2.5 clk = ~clk;

  mem_err_capture u_dut (
    .clk(clk), .rst_n(rst_n),
    .sbe_evt(sbe_evt), .sbe_addr(sbe_addr), .sbe_row(sbe_row),
    .mbe_evt(mbe_evt), .mbe_addr(mbe_addr), .mbe_row(mbe_row),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .serr_o(serr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Samples serr one ns after the edge, then reads the three words in turn.
  task automatic check_all(input string tag);
    chk({tag, " serr_o"}, {31'b0, serr_o}, {31'b0, e_serr});
    reg_sel = 2'd0; #0.5;
    chk({tag, " address word"}, reg_rdata, {e_page, 10'b0, e_flag});
    reg_sel = 2'd1; #0.5;
    chk({tag, " status word"}, reg_rdata, {24'b0, e_row1, e_seen[1], e_row0, e_seen[0]});
    reg_sel = 2'd2; #0.5;
    chk({tag, " command word"}, reg_rdata, {30'b0, e_cmd});
  endtask

  task automatic step(input bit se, input bit [31:0] sa, input bit [2:0] sr,
                      input bit me, input bit [31:0] ma, input bit [2:0] mr,
                      input bit wr, input bit [1:0] sel, input bit [31:0] wd);
    bit [1:0] cap;
    bit [1:0] clr;
    cap[0] = se && !e_flag[0];
    cap[1] = me && !e_flag[1];
    clr    = (wr && sel == 2'd0) ? wd[1:0] : 2'b00;
    if (cap[1]) e_page = ma[31:12];
    else if (cap[0] && !e_flag[1]) e_page = sa[31:12];
    e_serr = |(cap & e_cmd);
    e_flag = (e_flag & ~clr) | cap;
    if (se && !e_seen[0]) begin e_seen[0] = 1'b1; e_row0 = sr; end
    else if (wr && sel == 2'd1 && wd[0]) begin e_seen[0] = 1'b0; e_row0 = 3'd0; end
    if (me && !e_seen[1]) begin e_seen[1] = 1'b1; e_row1 = mr; end
    else if (wr && sel == 2'd1 && wd[4]) begin e_seen[1] = 1'b0; e_row1 = 3'd0; end
    if (wr && sel == 2'd2) e_cmd = wd[1:0];
    sbe_evt = se; sbe_addr = sa; sbe_row = sr;
    mbe_evt = me; mbe_addr = ma; mbe_row = mr;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    @(posedge clk); #1;
    sbe_evt = 1'b0; mbe_evt = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic idle();
    step(0, 32'h0, 3'd0, 0, 32'h0, 3'd0, 0, 2'd3, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sbe_evt = 0; mbe_evt = 0; reg_wr = 0;
    sbe_addr = 0; mbe_addr = 0; sbe_row = 0; mbe_row = 0;
    reg_sel = 0; reg_wdata = 0;
    // events during reset must not register (R1)
    step(1, 32'hFFFF_F000, 3'd7, 1, 32'hFFFF_F000, 3'd7, 1, 2'd2, 32'h3);
    e_page = 0; e_flag = 0; e_seen = 0; e_row0 = 0; e_row1 = 0; e_cmd = 0; e_serr = 0;
    repeat (2) @(posedge clk);
    #1; check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) idle();
    check_all("R1 after release");

    step(0, 0, 0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFD);
    check_all("R9 enable single-bit only");

    step(1, 32'h1234_5678, 3'd5, 0, 0, 0, 0, 2'd3, 0);
    check_all("R3 first single-bit capture");

    step(1, 32'h8765_4321, 3'd2, 0, 0, 0, 0, 2'd3, 0);
    check_all("R4 second single-bit ignored");

    step(0, 0, 0, 1, 32'hABCD_E000, 3'd6, 0, 2'd3, 0);
    check_all("R5 multi-bit overwrites page, R10 disabled");

    step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0001);
    check_all("R6 clear single-bit flag");

    step(1, 32'h0000_1FFF, 3'd1, 0, 0, 0, 0, 2'd3, 0);
    check_all("R4 single-bit blocked by multi-bit page");

    step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'hFFFF_FFFC);
    check_all("R6 zero bits no effect");

    step(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_0001);
    check_all("R8 clear single-bit seen");

    step(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'hFFFF_FFEE);
    check_all("R8 zero seen bits no effect");

    step(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_0010);
    check_all("R8 clear multi-bit seen");

    step(0, 0, 0, 0, 0, 0, 1, 2'd2, 32'h0000_0003);
    check_all("R9 enable both");

    step(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_0003);
    check_all("R6 clear both flags");

    step(1, 32'h0111_1000, 3'd3, 1, 32'h0222_2000, 3'd4, 0, 2'd3, 0);
    check_all("R5 simultaneous, R7 rows, R10 pulse");

    idle();
    check_all("R10 pulse lasts one cycle");

    for (int i = 0; i < 3000; i++) begin
      bit [31:0] r0, r1, r2, r3;
      r0 = $urandom; r1 = $urandom; r2 = $urandom; r3 = $urandom;
      step(r0[1:0] == 2'b00, r1, r0[4:2],
           r0[7:5] == 3'b000, r2, r0[10:8],
           r0[13:11] == 3'b000, r0[15:14], r3);
      check_all("R2/R7/R9/R10 sweep");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule